// File: doc/BRIEF.md
# BCD Calendar Clock with Read Snapshot

This block holds the time of day and the calendar in packed BCD: seconds, minutes, hours, day of month, month, a two-digit year with the century implied, and a weekday. It moves forward by one second on each cycle where the tick-enable input is high and counting is switched on. A prescaler outside the block produces the tick.

Software reaches the block through a byte-wide register port. Writes are synchronous and reads are combinational. A control register has four jobs. It starts and stops counting, so software can freeze the clock and load a new time. It selects 12-hour or 24-hour presentation of the hour. It takes a one-shot command that copies six time bytes into shadow registers. It switches reads of those six bytes over to the shadow copy, so software sees one coherent set even if a tick arrives between byte reads. A status register reports whether the counter is running.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the counters read 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0. The control register (offset 0x0C) reads 0x00 and the status register (offset 0x0D) reads 0x00.
- R2: The time advances by one second on a clock edge only when control bit 0 is 1 and `tick_en` is high. While bit 0 is 0, ticks leave every counter unchanged.
- R3: Seconds and minutes wrap from 0x59 to 0x00 and carry to the next field. Hours wrap from 0x23 to 0x00 and carry into the day.
- R4: The day of month wraps to 0x01 after 0x30 in months 04, 06, 09 and 11. It wraps after 0x31 in the other months except February. February wraps after 0x29 when the BCD year is divisible by 4, and after 0x28 otherwise. Month wraps 0x12 to 0x01 and carries to the year, and the year wraps 0x99 to 0x00.
- R5: The weekday (offset 0x06) counts 0 to 6, steps on every day change, and wraps from 6 to 0.
- R6: A write to offsets 0x00 to 0x06 (seconds, minutes, hours, day, month, year, weekday) loads that live counter at the write edge. If a tick lands on the same edge, the write wins and the tick is dropped.
- R7: Writing control with bit 6 set copies seconds through year into the shadow registers on the next edge. Bit 6 reads 1 for that one cycle and then reads 0.
- R8: While control bit 7 is 1, reads of offsets 0x00 to 0x05 return the shadow copy. While bit 7 is 0 they return the live counters. The weekday always reads live.
- R9: While control bit 3 is 1, the hour reads as BCD 0x01 to 0x12 with bit 7 marking PM (0 h reads 0x12, 12 h reads 0x92, 13 h reads 0x81). Hour writes are decoded in the same form. Counting always follows the 24-hour day.
- R10: Status bit 1 reads 1 exactly when control bit 0 is 1. Reads of unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-second advance enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |

## Verification
A register write, and a tick with its whole carry chain, both show up on `rdata` right after the clock edge that samples them. A snapshot needs a second edge after the control write: the copy happens there, and the command bit drops at that same edge. The bench drives every stimulus on a falling edge and holds it through one rising edge. It reads back on a later falling edge, 1 ns after setting `addr`. This places every check after the edge that produces the expected value. The snapshot test reads control once between the two edges and once after the second, so the one-cycle command bit is observed directly.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HR   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DAY  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_YR   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_WD   = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(13);

  logic [7:0] sec_q, min_q, hr_q, day_q, mon_q, yr_q, wd_q;
  logic [7:0] sh_sec, sh_min, sh_hr, sh_day, sh_mon, sh_yr;
  logic       run_q, h12_q, snap_q, shr_q;

  function automatic logic [6:0] b2i(input logic [7:0] b);
    return 7'(b[7:4] * 4'd10) + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [7:0] binc(input logic [7:0] b);
    return (b[3:0] == 4'h9) ? {b[7:4] + 4'd1, 4'd0} : b + 8'd1;
  endfunction

  function automatic logic [7:0] hr_in(input logic [7:0] w);
    logic [6:0] h;
    h = b2i({3'b000, w[4:0]});
    if (h == 7'd12) return w[7] ? 8'h12 : 8'h00;
    return w[7] ? i2b(h + 7'd12) : i2b(h);
  endfunction

  function automatic logic [7:0] hr_out(input logic [7:0] r);
    logic [6:0] h;
    h = b2i(r);
    if (h == 7'd0)  return 8'h12;
    if (h < 7'd12)  return r;
    if (h == 7'd12) return 8'h92;
    return 8'h80 | i2b(h - 7'd12);
  endfunction

  logic       leap, wr_time, adv, c_s, c_m, c_h, c_d, c_mo;
  logic [7:0] dmax;

  assign leap = yr_q[4] ? (yr_q[3:0] == 4'h2 || yr_q[3:0] == 4'h6)
                        : (yr_q[3:0] == 4'h0 || yr_q[3:0] == 4'h4 || yr_q[3:0] == 4'h8);

  always_comb begin
    case (mon_q)
      8'h02:                    dmax = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: dmax = 8'h30;
      default:                  dmax = 8'h31;
    endcase
  end

  assign wr_time = wr_en && (addr <= A_WD);
  assign adv     = run_q && tick_en && !wr_time;
  assign c_s     = sec_q == 8'h59;
  assign c_m     = c_s && min_q == 8'h59;
  assign c_h     = c_m && hr_q == 8'h23;
  assign c_d     = c_h && day_q == dmax;
  assign c_mo    = c_d && mon_q == 8'h12;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= 8'h00; min_q <= 8'h00; hr_q <= 8'h00;
      day_q <= 8'h01; mon_q <= 8'h01; yr_q <= 8'h00; wd_q <= 8'h00;
      sh_sec <= 8'h00; sh_min <= 8'h00; sh_hr <= 8'h00;
      sh_day <= 8'h01; sh_mon <= 8'h01; sh_yr <= 8'h00;
      run_q <= 1'b0; h12_q <= 1'b0; snap_q <= 1'b0; shr_q <= 1'b0;
    end else begin
      if (snap_q) begin
        sh_sec <= sec_q; sh_min <= min_q; sh_hr <= hr_q;
        sh_day <= day_q; sh_mon <= mon_q; sh_yr <= yr_q;
        snap_q <= 1'b0;
      end
      if (wr_en) begin
        case (addr)
          A_SEC:  sec_q <= wdata;
          A_MIN:  min_q <= wdata;
          A_HR:   hr_q  <= h12_q ? hr_in(wdata) : wdata;
          A_DAY:  day_q <= wdata;
          A_MON:  mon_q <= wdata;
          A_YR:   yr_q  <= wdata;
          A_WD:   wd_q  <= wdata;
          A_CTRL: begin
            run_q  <= wdata[0];
            h12_q  <= wdata[3];
            snap_q <= wdata[6];
            shr_q  <= wdata[7];
          end
          default: ;
        endcase
      end
      if (adv) begin
        sec_q <= c_s ? 8'h00 : binc(sec_q);
        if (c_s) min_q <= c_m ? 8'h00 : binc(min_q);
        if (c_m) hr_q  <= c_h ? 8'h00 : binc(hr_q);
        if (c_h) begin
          day_q <= c_d ? 8'h01 : binc(day_q);
          wd_q  <= (wd_q >= 8'h06) ? 8'h00 : wd_q + 8'd1;
        end
        if (c_d)  mon_q <= c_mo ? 8'h01 : binc(mon_q);
        if (c_mo) yr_q  <= (yr_q == 8'h99) ? 8'h00 : binc(yr_q);
      end
    end
  end

  logic [7:0] hr_sel;
  assign hr_sel = shr_q ? sh_hr : hr_q;

  always_comb begin
    case (addr)
      A_SEC:   rdata = shr_q ? sh_sec : sec_q;
      A_MIN:   rdata = shr_q ? sh_min : min_q;
      A_HR:    rdata = h12_q ? hr_out(hr_sel) : hr_sel;
      A_DAY:   rdata = shr_q ? sh_day : day_q;
      A_MON:   rdata = shr_q ? sh_mon : mon_q;
      A_YR:    rdata = shr_q ? sh_yr : yr_q;
      A_WD:    rdata = wd_q;
      A_CTRL:  rdata = {shr_q, snap_q, 2'b00, h12_q, 2'b00, run_q};
      A_STAT:  rdata = {6'b0, run_q, 1'b0};
      default: rdata = 8'h00;
    endcase
  end

  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(day_q)));

  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sec_q == 8'h59) |=> (sec_q == 8'h00));

  a_r4_day_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && c_h && day_q == dmax) |=> (day_q == 8'h01));

  a_r5_wday_range: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wd_q <= 8'h06) |=> (wd_q <= 8'h06));

  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SEC) |=> (sec_q == $past(wdata)));

  a_r7_snap_once: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_q && !(wr_en && addr == A_CTRL)) |=> !snap_q);

  a_r7_snap_copy: assert property (@(posedge clk) disable iff (!rst_n)
    snap_q |=> (sh_sec == $past(sec_q) && sh_yr == $past(yr_q)));

endmodule

// File: tb/bcd_rtc_core_tb.sv
`timescale 1ns/1ps
module bcd_rtc_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_rtc_core #(.ADDR_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic load(input logic [7:0] s, m, h, d, mo, y, w);
    wr(5'd12, 8'h00);
    wr(5'd0, s); wr(5'd1, m); wr(5'd2, h); wr(5'd3, d);
    wr(5'd4, mo); wr(5'd5, y); wr(5'd6, w);
    wr(5'd12, 8'h01);
  endtask

  task automatic t_reset();
    rd_chk("R1 sec", 5'd0, 8'h00);  rd_chk("R1 min", 5'd1, 8'h00);
    rd_chk("R1 hr", 5'd2, 8'h00);   rd_chk("R1 day", 5'd3, 8'h01);
    rd_chk("R1 mon", 5'd4, 8'h01);  rd_chk("R1 yr", 5'd5, 8'h00);
    rd_chk("R1 wd", 5'd6, 8'h00);   rd_chk("R1 ctrl", 5'd12, 8'h00);
    rd_chk("R1 stat", 5'd13, 8'h00);
  endtask

  task automatic t_gate();
    tick(2);
    rd_chk("R2 stopped", 5'd0, 8'h00);
    wr(5'd12, 8'h01);
    tick(3);
    rd_chk("R2 running", 5'd0, 8'h03);
    @(negedge clk); @(negedge clk);
    rd_chk("R2 no tick", 5'd0, 8'h03);
  endtask

  task automatic t_roll();
    load(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h06);
    tick(1);
    rd_chk("R3 sec", 5'd0, 8'h00); rd_chk("R3 min", 5'd1, 8'h00);
    rd_chk("R3 hr", 5'd2, 8'h00);  rd_chk("R4 day", 5'd3, 8'h01);
    rd_chk("R4 mon", 5'd4, 8'h01); rd_chk("R4 yr", 5'd5, 8'h00);
    rd_chk("R5 wd wrap", 5'd6, 8'h00);
    load(8'h59, 8'h09, 8'h05, 8'h10, 8'h03, 8'h10, 8'h02);
    tick(1);
    rd_chk("R3 min bcd", 5'd1, 8'h10);
    rd_chk("R5 wd hold", 5'd6, 8'h02);
  endtask

  task automatic t_months();
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h02);
    tick(1);
    rd_chk("R4 leap day", 5'd3, 8'h29); rd_chk("R4 leap mon", 5'd4, 8'h02);
    rd_chk("R5 wd step", 5'd6, 8'h03);
    load(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24, 8'h03);
    tick(1);
    rd_chk("R4 leap end", 5'd4, 8'h03); rd_chk("R4 leap end day", 5'd3, 8'h01);
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h00);
    tick(1);
    rd_chk("R4 common feb", 5'd4, 8'h03);
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h00, 8'h00);
    tick(1);
    rd_chk("R4 year00 leap", 5'd3, 8'h29);
    load(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h05, 8'h00);
    tick(1);
    rd_chk("R4 april", 5'd4, 8'h05);
    load(8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h05, 8'h00);
    tick(1);
    rd_chk("R4 may 31", 5'd3, 8'h31);
  endtask

  task automatic t_write_wins();
    load(8'h40, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; addr = 5'd0; wdata = 8'h10;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rd_chk("R6 write wins", 5'd0, 8'h10);
    rd_chk("R6 min untouched", 5'd1, 8'h00);
  endtask

  task automatic t_snap();
    load(8'h20, 8'h15, 8'h08, 8'h07, 8'h06, 8'h25, 8'h01);
    wr(5'd12, 8'hC1);
    rd_chk("R7 snap bit high", 5'd12, 8'hC1);
    @(negedge clk);
    rd_chk("R7 snap bit clear", 5'd12, 8'h81);
    tick(2);
    rd_chk("R8 shadow sec", 5'd0, 8'h20);
    rd_chk("R8 shadow min", 5'd1, 8'h15);
    rd_chk("R8 shadow yr", 5'd5, 8'h25);
    wr(5'd12, 8'h01);
    rd_chk("R8 live sec", 5'd0, 8'h22);
  endtask

  task automatic t_12h();
    wr(5'd12, 8'h00);
    wr(5'd2, 8'h13);
    wr(5'd12, 8'h08);
    rd_chk("R9 13h", 5'd2, 8'h81);
    wr(5'd2, 8'h92);
    rd_chk("R9 noon 12h", 5'd2, 8'h92);
    wr(5'd12, 8'h00);
    rd_chk("R9 noon 24h", 5'd2, 8'h12);
    wr(5'd12, 8'h08);
    wr(5'd2, 8'h12);
    rd_chk("R9 midnight 12h", 5'd2, 8'h12);
    wr(5'd12, 8'h00);
    rd_chk("R9 midnight 24h", 5'd2, 8'h00);
  endtask

  task automatic t_status();
    wr(5'd12, 8'h01);
    rd_chk("R10 running", 5'd13, 8'h02);
    wr(5'd12, 8'h00);
    rd_chk("R10 stopped", 5'd13, 8'h00);
    rd_chk("R10 unmapped", 5'd31, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_roll();
    t_months();
    t_write_wins();
    t_snap();
    t_12h();
    t_status();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule